// File: doc/BRIEF.md
# Four-Channel Shared-Counter Pulse-Width Modulator

This block produces pulse-width modulated outputs on several channels that all share one counter, one clock divider and one top value. Software fills a small bank of per-channel words (compare value plus a polarity flag), programs the counter top, the divider exponent and the counting style, then issues a start command. The start copies every channel word and the configuration into the running copies. The outputs then keep generating from those copies until software issues a fresh start, which swaps in new words at the next period boundary, or a stop.

The counter runs either edge-aligned (it counts up, then wraps) or center-aligned (it counts up to the top, then back down, which doubles the period). A stop is not immediate. The current period finishes first, and only then does the block go idle and raise its stopped flag. Start commands that arrive during that wind-down are dropped. While the block is idle, each output rests at the inactive level given by the polarity flag of its buffered word.

Top module: `pwm_seq_gen`

## Requirements
- R1: After reset the stopped flag is 1, the top value and configuration read back as 0, every channel word reads back as 16'h8000, and all outputs are low.
- R2: A channel word holds its compare value in bits 14:0 and its polarity in bit 15. With bit 15 set the output is high while the counter is below the compare value and low otherwise. With bit 15 clear the output is the complement of that.
- R3: In edge-aligned mode (configuration bit 0 = 0) the counter steps 0, 1, ..., top and then returns to 0, so a period lasts top+1 counts.
- R4: In center-aligned mode (configuration bit 0 = 1) the counter steps 0, 1, ..., top, top-1, ..., 1 and then returns to 0, so a period lasts 2*top counts (1 count when top is 0).
- R5: A compare value of 0 holds the output at its inactive level. Any other compare value that is greater than or equal to top holds the output at its active level.
- R6: The counter advances once every 2^p clocks, where p is configuration bits 3:1.
- R7: A start written while stopped loads the top, the divider, the mode and all channel words, and the counter reads 0 in the first cycle after the write.
- R8: A start written while running takes the current channel words at the first period boundary after the write. Writes to top, divider or mode made while running have no effect until the block is stopped and started again.
- R9: A stop written while running lets the current period finish. The block goes idle at the next period boundary, and the stopped flag reads 0 until then and 1 afterwards.
- R10: A start written between a stop and the period boundary that completes that stop is ignored. The block still goes idle at that boundary.
- R11: While stopped, each output drives the inverse of bit 15 of its buffered word.
- R12: Register map: address 0 is the configuration (bit 0 mode, bits 3:1 divider exponent), address 1 is the top value (bits 14:0), address 2 is the command (bit 0 start, bit 1 stop; stop wins when both are set), address 3 is the status (bit 0 stopped), and addresses 4 to 7 are the words for channels 0 to 3. The configuration, the top value and the channel words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | Channel outputs |
| stopped | output | 1 | High while the block is idle |

## Verification
The bench builds the block with its default parameters: four channels, a 15-bit counter and a 3-bit divider exponent. It programs small top values (0, 2, 3 and 4) and divider exponents 0 to 2, so that complete periods, both counting styles, top-value corner cases and the boundary-timed stop and reload all fit within a few dozen cycles. Channel words are chosen to cover both polarities, zero compare values, compare values equal to top and compare values above top.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

    // Run-state of the generator
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_STOPPING = 2'd2
    } run_state_e;

    // Register indices (R12)
    localparam int REG_CFG  = 0;
    localparam int REG_TOP  = 1;
    localparam int REG_CMD  = 2;
    localparam int REG_STAT = 3;
    localparam int REG_SEQ0 = 4;

    // Command bits
    localparam int CMD_START_BIT = 0;
    localparam int CMD_STOP_BIT  = 1;

endpackage

// File: rtl/pwm_seq_regs.sv
module pwm_seq_regs import pwm_seq_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 15,
    parameter int PSC_W  = 3,
    parameter int ADDR_W = 3,
    localparam int WORD_W = CNT_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic                           stopped,
    output logic [WORD_W-1:0]              rd_data,
    output logic                           cfg_center,
    output logic [PSC_W-1:0]               cfg_psc,
    output logic [CNT_W-1:0]               cfg_top,
    output logic [NUM_CH-1:0][WORD_W-1:0]  seq_words,
    output logic                           start_cmd,
    output logic                           stop_cmd
);

    typedef struct packed {
        logic                          center;
        logic [PSC_W-1:0]              psc;
        logic [CNT_W-1:0]              top;
        logic [NUM_CH-1:0][WORD_W-1:0] seq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_CFG)) begin
                r_d.center = wr_data[0];
                r_d.psc    = wr_data[PSC_W:1];
            end
            if (wr_addr == ADDR_W'(REG_TOP)) begin
                r_d.top = wr_data[CNT_W-1:0];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == ADDR_W'(REG_SEQ0 + i)) begin
                    r_d.seq[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                r_q.seq[i][CNT_W] <= 1'b1;
            end
        end else begin
            r_q <= r_d;
        end
    end

    // Command decode: pulses for one cycle with the write
    always_comb begin
        start_cmd = wr_en && (wr_addr == ADDR_W'(REG_CMD)) && wr_data[CMD_START_BIT];
        stop_cmd  = wr_en && (wr_addr == ADDR_W'(REG_CMD)) && wr_data[CMD_STOP_BIT];
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_CFG)) begin
            rd_data[0]       = r_q.center;
            rd_data[PSC_W:1] = r_q.psc;
        end
        if (rd_addr == ADDR_W'(REG_TOP)) begin
            rd_data[CNT_W-1:0] = r_q.top;
        end
        if (rd_addr == ADDR_W'(REG_STAT)) begin
            rd_data[0] = stopped;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(REG_SEQ0 + i)) begin
                rd_data = r_q.seq[i];
            end
        end
    end

    assign cfg_center = r_q.center;
    assign cfg_psc    = r_q.psc;
    assign cfg_top    = r_q.top;
    assign seq_words  = r_q.seq;

endmodule

// File: rtl/pwm_seq_prescaler.sv
module pwm_seq_prescaler #(
    parameter int PSC_W = 3,
    localparam int DIV_W = (1 << PSC_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [DIV_W-1:0] pcnt_d, pcnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit  = ~(~DIV_W'(0) << psc);
        tick   = run && (pcnt_q == limit);
        pcnt_d = pcnt_q;
        if (clear) begin
            pcnt_d = '0;
        end else if (run) begin
            pcnt_d = tick ? '0 : pcnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_d;
        end
    end

    // R6: no two ticks in a row unless the divider is 1
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (psc != '0) && !clear) |=> !tick);

endmodule

// File: rtl/pwm_seq_counter.sv
module pwm_seq_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             period_end
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_state_t;

    cnt_state_t c_d, c_q;
    logic [CNT_W-1:0] nxt;
    logic             nxt_down;

    always_comb begin
        nxt      = c_q.cnt;
        nxt_down = c_q.down;
        if (!center) begin
            nxt      = (c_q.cnt >= top) ? '0 : c_q.cnt + CNT_W'(1);
            nxt_down = 1'b0;
        end else if (!c_q.down) begin
            if (c_q.cnt >= top) begin
                nxt      = (top == '0) ? '0 : top - CNT_W'(1);
                nxt_down = 1'b1;
            end else begin
                nxt = c_q.cnt + CNT_W'(1);
            end
        end else begin
            nxt = (c_q.cnt == '0) ? '0 : c_q.cnt - CNT_W'(1);
        end
        if (nxt == '0) begin
            nxt_down = 1'b0;
        end

        period_end = tick && (nxt == '0);

        c_d = c_q;
        if (clear) begin
            c_d = '0;
        end else if (tick) begin
            c_d.cnt  = nxt;
            c_d.down = nxt_down;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt = c_q.cnt;

    // R3: edge-aligned wraps to zero after reaching top
    a_r3_edge_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !center && (c_q.cnt >= top)) |=> (c_q.cnt == '0));

    // R4: center-aligned turns downward at top
    a_r4_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && center && !c_q.down && (c_q.cnt == top) && (top > CNT_W'(1)))
        |=> (c_q.down && (c_q.cnt == top - CNT_W'(1))));

endmodule

// File: rtl/pwm_seq_chan.sv
module pwm_seq_chan #(
    parameter int CNT_W = 15
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W:0]   word,
    input  logic [CNT_W:0]   idle_word,
    output logic             out
);

    logic [CNT_W-1:0] cmp;
    logic             act;

    always_comb begin
        cmp = word[CNT_W-1:0];
        act = (cmp != '0) && ((cmp >= top) || (cnt < cmp));
        if (running) begin
            out = word[CNT_W] ? act : !act;
        end else begin
            out = !idle_word[CNT_W];
        end
    end

endmodule

// File: rtl/pwm_seq_gen.sv
module pwm_seq_gen import pwm_seq_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 15,
    parameter int PSC_W  = 3,
    localparam int WORD_W = CNT_W + 1,
    localparam int ADDR_W = $clog2(REG_SEQ0 + NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              stopped
);

    typedef struct packed {
        run_state_e                    state;
        logic                          center;
        logic [PSC_W-1:0]              psc;
        logic [CNT_W-1:0]              top;
        logic [NUM_CH-1:0][WORD_W-1:0] seq;
        logic                          pend;
    } ctl_t;

    ctl_t q, d;

    logic                          cfg_center;
    logic [PSC_W-1:0]              cfg_psc;
    logic [CNT_W-1:0]              cfg_top;
    logic [NUM_CH-1:0][WORD_W-1:0] seq_words;
    logic                          start_cmd;
    logic                          stop_cmd;
    logic                          clear;
    logic                          tick;
    logic                          period_end;
    logic [CNT_W-1:0]              cnt;
    logic                          running;

    pwm_seq_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .PSC_W  (PSC_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .stopped    (stopped),
        .rd_data    (rd_data),
        .cfg_center (cfg_center),
        .cfg_psc    (cfg_psc),
        .cfg_top    (cfg_top),
        .seq_words  (seq_words),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd)
    );

    // Control: start, deferred reload, deferred stop
    always_comb begin
        d     = q;
        clear = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_cmd && !stop_cmd) begin
                    d.state  = ST_RUN;
                    d.center = cfg_center;
                    d.psc    = cfg_psc;
                    d.top    = cfg_top;
                    d.seq    = seq_words;
                    d.pend   = 1'b0;
                    clear    = 1'b1;
                end
            end
            ST_RUN: begin
                if (period_end && q.pend) begin
                    d.seq  = seq_words;
                    d.pend = 1'b0;
                end
                if (stop_cmd) begin
                    d.state = ST_STOPPING;
                    d.pend  = 1'b0;
                end else if (start_cmd) begin
                    d.pend = 1'b1;
                end
            end
            ST_STOPPING: begin
                if (period_end) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                q.seq[i][CNT_W] <= 1'b1;
            end
        end else begin
            q <= d;
        end
    end

    assign running = (q.state != ST_IDLE);
    assign stopped = (q.state == ST_IDLE);

    pwm_seq_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .run   (running),
        .psc   (q.psc),
        .tick  (tick)
    );

    pwm_seq_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .tick       (tick),
        .center     (q.center),
        .top        (q.top),
        .cnt        (cnt),
        .period_end (period_end)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_seq_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .running   (running),
            .cnt       (cnt),
            .top       (q.top),
            .word      (q.seq[i]),
            .idle_word (seq_words[i]),
            .out       (pwm_out[i])
        );

        // R5: zero compare stays inactive while running
        a_r5_zero_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            (running && (q.seq[i][CNT_W-1:0] == '0)) |-> (pwm_out[i] == !q.seq[i][CNT_W]));

        // R11: idle level follows the buffered polarity
        a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            stopped |-> (pwm_out[i] == !seq_words[i][CNT_W]));
    end

    // R3: counter stays within range while running
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= q.top));

    // R7: start from idle begins at count zero
    a_r7_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && start_cmd && !stop_cmd) |=> (running && (cnt == '0)));

    // R8: running configuration frozen
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(q.top) && $stable(q.psc) && $stable(q.center)));

    // R8: words change only at a period boundary
    a_r8_words_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_end) |=> $stable(q.seq));

    // R9: stop completes at the boundary
    a_r9_stop_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_STOPPING) && period_end) |=> stopped);

    // R10: wind-down is not cut short by a start
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_STOPPING) && !period_end) |=> (q.state == ST_STOPPING));

endmodule

// File: tb/tb_pwm_seq_gen.sv
module tb_pwm_seq_gen;

    localparam int AW = 3;
    localparam int W  = 16;

    localparam logic [AW-1:0] A_CFG  = 3'd0;
    localparam logic [AW-1:0] A_TOP  = 3'd1;
    localparam logic [AW-1:0] A_CMD  = 3'd2;
    localparam logic [AW-1:0] A_STAT = 3'd3;
    localparam logic [AW-1:0] A_SEQ0 = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic [3:0]    pwm_out;
    logic          stopped;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    pwm_seq_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out),
        .stopped (stopped)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compare outputs against the scoreboard each negedge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(pwm_out === e, t, int'(pwm_out), int'(e));
        end
    end

    // Reference model
    function automatic int cnt_at(int k, int top, int psc, bit center);
        int t;
        int p;
        t = k >> psc;
        if (!center) return t % (top + 1);
        if (top == 0) return 0;
        p = t % (2 * top);
        return (p <= top) ? p : (2 * top - p);
    endfunction

    function automatic int period_len(int top, int psc, bit center);
        int n;
        n = center ? ((top == 0) ? 1 : 2 * top) : (top + 1);
        return n << psc;
    endfunction

    function automatic logic [3:0] run_vec(int k, int top, int psc, bit center,
                                           logic [3:0][15:0] ws);
        logic [3:0] v;
        int c;
        c = cnt_at(k, top, psc, center);
        for (int i = 0; i < 4; i++) begin
            int  cmp;
            bit  act;
            cmp  = int'(ws[i][14:0]);
            act  = (cmp != 0) && ((cmp >= top) || (c < cmp));
            v[i] = ws[i][15] ? act : !act;
        end
        return v;
    endfunction

    function automatic logic [3:0] idle_vec(logic [3:0][15:0] ws);
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = !ws[i][15];
        return v;
    endfunction

    task automatic push(input logic [3:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Write captured at the posedge that brings cyc to t
    task automatic wr_at(input int t, input logic [AW-1:0] a, input logic [W-1:0] dv);
        @(negedge clk);
        while (cyc < t - 1) @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = dv;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] dv);
        wr_at(cyc + 1, a, dv);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [W-1:0] expv, input string req);
        rd_addr = a;
        #1;
        check(rd_data === expv, req, int'(rd_data), int'(expv));
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(posedge clk);
        #1;
    endtask

    task automatic load_words(input logic [3:0][15:0] ws);
        for (int i = 0; i < 4; i++) wr(A_SEQ0 + AW'(i), ws[i]);
    endtask

    // Start, run, stop at relative edge stop_j; idle after the boundary
    task automatic run_case(input int top, input int psc, input bit center,
                            input logic [3:0][15:0] ws, input int stop_j,
                            input int n, input string tag);
        int c0;
        int len;
        int stop_k;
        len    = period_len(top, psc, center);
        stop_k = ((stop_j / len) + 1) * len;
        wr(A_CMD, 16'h0001);
        c0 = cyc;
        for (int k = 0; k < n; k++) begin
            if (k < stop_k) push(run_vec(k, top, psc, center, ws), tag);
            else            push(idle_vec(ws), "R9 idle after boundary");
        end
        wr_at(c0 + stop_j, A_CMD, 16'h0002);
        drain();
        check(stopped === 1'b1, "R9 stopped flag", int'(stopped), 1);
    endtask

    logic [3:0][15:0] wa;
    logic [3:0][15:0] wb;
    logic [3:0][15:0] wc;

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        wa = {16'h8004, 16'h8000, 16'h0002, 16'h8002};
        wb = {16'h0000, 16'h8004, 16'h0001, 16'h8003};
        wc = {16'h8000, 16'h0001, 16'h8002, 16'h8001};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(stopped === 1'b1, "R1 stopped", int'(stopped), 1);
        check(pwm_out === 4'b0000, "R1 outputs", int'(pwm_out), 0);
        rd_check(A_TOP, 16'h0000, "R1 top");
        rd_check(A_CFG, 16'h0000, "R1 cfg");
        rd_check(A_SEQ0 + 3'd2, 16'h8000, "R1 word");

        // R12 register readback
        wr(A_TOP, 16'd4);
        wr(A_CFG, 16'h0000);
        load_words(wa);
        rd_check(A_TOP, 16'd4, "R12 top");
        rd_check(A_SEQ0 + 3'd1, 16'h0002, "R12 word1");
        wr(A_CFG, 16'h0005);
        rd_check(A_CFG, 16'h0005, "R12 cfg");
        wr(A_CFG, 16'h0000);

        // R11 idle levels follow buffered polarity
        for (int k = 0; k < 3; k++) push(idle_vec(wa), "R11 idle level");
        drain();

        // R12 stop wins over start in the same write
        wr(A_CMD, 16'h0003);
        rd_check(A_STAT, 16'h0001, "R12 stop wins");
        for (int k = 0; k < 2; k++) push(idle_vec(wa), "R12 stays idle");
        drain();

        // R2 R3 R7 R8 R9 R10: edge mode top 4, reload, deferred top, stop
        wr(A_CMD, 16'h0001);
        c0 = cyc;
        for (int k = 0; k < 25; k++) begin
            if (k < 10)      push(run_vec(k, 4, 0, 1'b0, wa), "R3 R2 R7 edge run");
            else if (k < 15) push(run_vec(k, 4, 0, 1'b0, wb), "R8 reload at boundary");
            else             push(idle_vec(wb), "R9 R10 idle after stop");
        end
        for (int i = 0; i < 4; i++) wr_at(c0 + 3 + i, A_SEQ0 + AW'(i), wb[i]);
        wr_at(c0 + 7, A_CMD, 16'h0001);
        wr_at(c0 + 8, A_TOP, 16'd2);
        wr_at(c0 + 12, A_CMD, 16'h0002);
        wr_at(c0 + 13, A_CMD, 16'h0001);
        rd_addr = A_STAT;
        @(negedge clk);
        check(rd_data === 16'h0000, "R9 not yet stopped", int'(rd_data), 0);
        drain();
        check(stopped === 1'b1, "R10 start ignored", int'(stopped), 1);

        // R4 R6 R5: center mode, top 2, divide by 2
        load_words(wc);
        wr(A_CFG, 16'h0003);
        run_case(2, 1, 1'b1, wc, 9, 20, "R4 R6 center run");

        // R6 R3: edge mode, top 3, divide by 4
        wr(A_TOP, 16'd3);
        wr(A_CFG, 16'h0004);
        run_case(3, 2, 1'b0, wc, 40, 52, "R6 divide by four");

        // R5: top 0 corner
        wr(A_TOP, 16'd0);
        wr(A_CFG, 16'h0000);
        run_case(0, 0, 1'b0, wc, 6, 10, "R5 top zero");

        // R4 R5: center mode with top 3 and words B
        load_words(wb);
        wr(A_TOP, 16'd3);
        wr(A_CFG, 16'h0001);
        run_case(3, 0, 1'b1, wb, 8, 16, "R4 R5 center top three");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule